// File: doc/BRIEF.md
# Two-Level Page Walker with Fault Reporting

This block resolves a virtual-to-physical translation when the translation cache misses. Given a linear address, the kind of access (read or write), the privilege of the requester (user or supervisor) and the page-directory base, it fetches the directory entry, then the table entry, over a simple request/acknowledge memory port. Along the way it marks entries as accessed, and marks the final entry dirty on a write. It then either hands a page-number/frame pair to the translation cache or signals a page fault.

A fault carries a 16-bit cause code and the faulting linear address. The address is held in a register until the next fault. The walker handles one walk at a time. A new request is accepted only when the walker is idle. Dispatch of the exception and segmentation are left to neighbouring logic.

Entry word layout used throughout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bits [31:12] frame number.

Top module: `page_walker`

## Requirements
- R1: After reset the walker is idle: `walk_busy`, `mem_req`, `fill_vld` and `flt_vld` are 0, and `flt_addr` and `flt_code` are 0.
- R2: The first memory transaction of a walk is a read at address {`dir_base`[31:12], `walk_lin`[31:22], 2'b00}.
- R3: If the directory entry has bit 0 = 0, the walk ends in a fault with code bit 0 = 0, and no further memory transaction is made.
- R4: A present directory entry with bit 5 = 0 is written back, with bit 5 set and the other bits unchanged, to the same address before the table read. If bit 5 is already 1, no directory write occurs.
- R5: The table entry is read at address {directory entry[31:12], `walk_lin`[21:12], 2'b00}.
- R6: A table entry with bit 0 = 0 ends the walk in a fault with code bit 0 = 0 and no write-back of the table entry.
- R7: A present, permitted table entry is written back with bit 5 set, and also bit 6 set when the access is a write. The write is skipped when the needed bits are already set.
- R8: A user access faults with code bit 0 = 1 unless bit 2 is set in both entries. A user write also needs bit 1 set in both entries. Supervisor accesses never take a protection fault. A protection fault writes no table entry back.
- R9: `flt_code` bit 1 is 1 for a write and 0 for a read. Bit 2 is 1 for user and 0 for supervisor. Bits [15:3] are 0.
- R10: `flt_addr` takes the faulting linear address when a fault occurs and keeps it through later successful walks.
- R11: A successful walk pulses `fill_vld` for one cycle with `fill_vpn` = `walk_lin`[31:12] and `fill_frame` = table entry[31:12]. A fault pulses `flt_vld` for one cycle. The two never coincide, and the walker is idle the cycle after either pulse.
- R12: `mem_req`, `mem_we` and `mem_addr` stay steady until `mem_ack`. A `walk_req` raised while `walk_busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_req | input | 1 | Start a walk (taken only when idle) |
| walk_lin | input | 32 | Linear address that missed |
| walk_wr | input | 1 | 1 = write access, 0 = read |
| walk_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 32 | Page-directory base register |
| walk_busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write transaction |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write-back entry value |
| mem_ack | input | 1 | Transaction done (read data valid) |
| mem_rdata | input | 32 | Read entry value |
| fill_vld | output | 1 | Translation-cache fill strobe |
| fill_vpn | output | 20 | Virtual page number for the fill |
| fill_frame | output | 20 | Physical frame for the fill |
| flt_vld | output | 1 | Page-fault strobe |
| flt_code | output | 16 | Fault cause code |
| flt_addr | output | 32 | Latched faulting linear address |

## Verification
The bench builds the walker with its default 12-bit page offset. This gives 10-bit directory and table indices and a 32-bit linear address, so every bit position in the requirements is the one exercised. A memory model in the bench logs each transaction, which lets each scenario compare the exact address, direction and write data sequence against values derived from the entry layout. The scenarios cover both not-present levels, each protection combination, repeated walks to one page that shrink the write-backs step by step, and a request issued mid-walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ENT_W = 32;
  localparam int B_P   = 0;
  localparam int B_RW  = 1;
  localparam int B_US  = 2;
  localparam int B_A   = 5;
  localparam int B_D   = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_WR_DIR, S_RD_TBL, S_CHECK, S_WR_TBL, S_FILL, S_FAULT
  } walk_st_t;

  // Entry value after marking it accessed (and dirty when asked)
  function automatic logic [ENT_W-1:0] mark_entry(input logic [ENT_W-1:0] e,
                                                  input logic dirty);
    logic [ENT_W-1:0] m;
    m = '0;
    m[B_A] = 1'b1;
    m[B_D] = dirty;
    return e | m;
  endfunction
endpackage

// File: rtl/pw_perm.sv
module pw_perm
  import pw_pkg::*;
(
  input  logic [ENT_W-1:0] dir_ent,
  input  logic [ENT_W-1:0] tbl_ent,
  input  logic             is_user,
  input  logic             is_wr,
  output logic             viol
);
  logic both_user, both_wr;
  assign both_user = dir_ent[B_US] & tbl_ent[B_US];
  assign both_wr   = dir_ent[B_RW] & tbl_ent[B_RW];
  // Supervisor ignores both the user and the writable bits
  assign viol = is_user & (~both_user | (is_wr & ~both_wr));
endmodule

// File: rtl/pw_fault_reg.sv
module pw_fault_reg #(
  parameter int LIN_W = 32,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [LIN_W-1:0] lin,
  input  logic             prot,
  input  logic             is_wr,
  input  logic             is_user,
  output logic [LIN_W-1:0] flt_addr,
  output logic [ERR_W-1:0] flt_code
);
  function automatic logic [ERR_W-1:0] make_code(input logic p, input logic w,
                                                 input logic u);
    logic [ERR_W-1:0] c;
    c = '0;
    c[0] = p;
    c[1] = w;
    c[2] = u;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_addr <= '0;
      flt_code <= '0;
    end else if (take) begin
      flt_addr <= lin;
      flt_code <= make_code(prot, is_wr, is_user);
    end
  end

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(flt_addr));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int ERR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   walk_req,
  input  logic [OFF_W*3-5:0]     walk_lin,
  input  logic                   walk_wr,
  input  logic                   walk_user,
  input  logic [ENT_W-1:0]       dir_base,
  output logic                   walk_busy,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ENT_W-1:0]       mem_addr,
  output logic [ENT_W-1:0]       mem_wdata,
  input  logic                   mem_ack,
  input  logic [ENT_W-1:0]       mem_rdata,
  output logic                   fill_vld,
  output logic [OFF_W*2-5:0]     fill_vpn,
  output logic [ENT_W-OFF_W-1:0] fill_frame,
  output logic                   flt_vld,
  output logic [ERR_W-1:0]       flt_code,
  output logic [OFF_W*3-5:0]     flt_addr
);
  localparam int IDX_W = OFF_W - 2;
  localparam int LIN_W = OFF_W + 2 * IDX_W;
  localparam int VPN_W = LIN_W - OFF_W;
  localparam int FRM_W = ENT_W - OFF_W;

  function automatic logic [ENT_W-1:0] dir_addr(input logic [FRM_W-1:0] base,
                                                input logic [LIN_W-1:0] lin);
    return {base, lin[LIN_W-1 -: IDX_W], 2'b00};
  endfunction

  function automatic logic [ENT_W-1:0] tbl_addr(input logic [FRM_W-1:0] frm,
                                                input logic [LIN_W-1:0] lin);
    return {frm, lin[OFF_W +: IDX_W], 2'b00};
  endfunction

  walk_st_t         st, st_nx;
  logic [LIN_W-1:0] lin_q;
  logic             wr_q, usr_q;
  logic [FRM_W-1:0] base_q;
  logic [ENT_W-1:0] dir_q, tbl_q;

  // Named internal events
  logic start_walk, dir_ack, dir_absent, tbl_ack, at_check;
  logic tbl_needs_wb, prot_viol, tbl_fault, fault_take, fault_is_prot;

  assign start_walk   = (st == S_IDLE) && walk_req;
  assign dir_ack      = (st == S_RD_DIR) && mem_ack;
  assign dir_absent   = dir_ack && !mem_rdata[B_P];
  assign tbl_ack      = (st == S_RD_TBL) && mem_ack;
  assign at_check     = (st == S_CHECK);
  assign tbl_needs_wb = !tbl_q[B_A] || (wr_q && !tbl_q[B_D]);
  assign tbl_fault    = !tbl_q[B_P] || prot_viol;
  assign fault_take   = dir_absent || (at_check && tbl_fault);
  assign fault_is_prot = at_check && tbl_q[B_P];

  pw_perm u_perm (
    .dir_ent (dir_q),
    .tbl_ent (tbl_q),
    .is_user (usr_q),
    .is_wr   (wr_q),
    .viol    (prot_viol)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:   if (walk_req) st_nx = S_RD_DIR;
      S_RD_DIR: if (mem_ack) begin
                  if (!mem_rdata[B_P])     st_nx = S_FAULT;
                  else if (!mem_rdata[B_A]) st_nx = S_WR_DIR;
                  else                      st_nx = S_RD_TBL;
                end
      S_WR_DIR: if (mem_ack) st_nx = S_RD_TBL;
      S_RD_TBL: if (mem_ack) st_nx = S_CHECK;
      S_CHECK:  if (tbl_fault)         st_nx = S_FAULT;
                else if (tbl_needs_wb) st_nx = S_WR_TBL;
                else                   st_nx = S_FILL;
      S_WR_TBL: if (mem_ack) st_nx = S_FILL;
      S_FILL:   st_nx = S_IDLE;
      S_FAULT:  st_nx = S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lin_q  <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      base_q <= '0;
      dir_q  <= '0;
      tbl_q  <= '0;
    end else begin
      st <= st_nx;
      if (start_walk) begin
        lin_q  <= walk_lin;
        wr_q   <= walk_wr;
        usr_q  <= walk_user;
        base_q <= dir_base[ENT_W-1:OFF_W];
      end
      if (dir_ack) dir_q <= mem_rdata;
      if (tbl_ack) tbl_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_req   = (st == S_RD_DIR) || (st == S_WR_DIR) ||
                (st == S_RD_TBL) || (st == S_WR_TBL);
    mem_we    = (st == S_WR_DIR) || (st == S_WR_TBL);
    mem_addr  = '0;
    mem_wdata = '0;
    if (st == S_RD_DIR || st == S_WR_DIR)
      mem_addr = dir_addr(base_q, lin_q);
    else if (st == S_RD_TBL || st == S_WR_TBL)
      mem_addr = tbl_addr(dir_q[ENT_W-1:OFF_W], lin_q);
    if (st == S_WR_DIR) mem_wdata = mark_entry(dir_q, 1'b0);
    if (st == S_WR_TBL) mem_wdata = mark_entry(tbl_q, wr_q);
  end

  assign walk_busy  = (st != S_IDLE);
  assign fill_vld   = (st == S_FILL);
  assign flt_vld    = (st == S_FAULT);
  assign fill_vpn   = lin_q[LIN_W-1:OFF_W];
  assign fill_frame = tbl_q[ENT_W-1:OFF_W];

  pw_fault_reg #(.LIN_W(LIN_W), .ERR_W(ERR_W)) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (fault_take),
    .lin      (lin_q),
    .prot     (fault_is_prot),
    .is_wr    (wr_q),
    .is_user  (usr_q),
    .flt_addr (flt_addr),
    .flt_code (flt_code)
  );

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_wb_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_A]);

  assert_dir_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_absent |=> !mem_req && flt_vld);

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_vld && flt_vld));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vld || flt_vld |=> !walk_busy && !fill_vld && !flt_vld);

  assert_sup_noprot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_vld && !flt_code[2] |-> !flt_code[0]);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_busy |-> !mem_req);
endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_req = 1'b0;
  logic [31:0] walk_lin = '0;
  logic        walk_wr = 1'b0;
  logic        walk_user = 1'b0;
  logic [31:0] dir_base = 32'h0001_0000;
  logic        walk_busy, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fill_vld, flt_vld;
  logic [19:0] fill_vpn, fill_frame;
  logic [15:0] flt_code;
  logic [31:0] flt_addr;

  page_walker u_page_walker (
    .clk(clk), .rst_n(rst_n), .walk_req(walk_req), .walk_lin(walk_lin),
    .walk_wr(walk_wr), .walk_user(walk_user), .dir_base(dir_base),
    .walk_busy(walk_busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .fill_vld(fill_vld), .fill_vpn(fill_vpn),
    .fill_frame(fill_frame), .flt_vld(flt_vld), .flt_code(flt_code),
    .flt_addr(flt_addr)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];
  logic        log_we   [16];
  int          log_n = 0;

  logic        got_fill, got_flt;
  logic [19:0] got_vpn, got_frame;
  logic [15:0] got_code;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] dir_at(input logic [31:0] lin);
    return (dir_base & 32'hFFFF_F000) | ((lin >> 22) << 2);
  endfunction

  function automatic logic [31:0] tbl_at(input logic [31:0] lin);
    return (rd_mem(dir_at(lin)) & 32'hFFFF_F000) | (((lin >> 12) & 32'h3FF) << 2);
  endfunction

  // Memory responder: one ack per request, one cycle after it appears
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (log_n < 16) begin
          log_addr[log_n] = mem_addr;
          log_we[log_n]   = mem_we;
          log_data[log_n] = mem_we ? mem_wdata : rd_mem(mem_addr);
        end
        log_n = log_n + 1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd_mem(mem_addr);
        mem_ack = 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic chk_txn(input string req, input int i, input logic [31:0] a,
                         input logic we, input logic [31:0] d);
    chk_eq(req, $sformatf("txn%0d addr", i), log_addr[i], a);
    chk_eq(req, $sformatf("txn%0d dir", i), {31'b0, log_we[i]}, {31'b0, we});
    if (we) chk_eq(req, $sformatf("txn%0d data", i), log_data[i], d);
  endtask

  // Launch a walk, optionally poke walk_req mid-walk, collect the outcome
  task automatic run_walk(input logic [31:0] lin, input logic wr,
                          input logic usr, input bit poke);
    bit done;
    log_n = 0;
    got_fill = 1'b0; got_flt = 1'b0;
    got_vpn = '0; got_frame = '0; got_code = '0;
    @(negedge clk);
    walk_lin = lin; walk_wr = wr; walk_user = usr; walk_req = 1'b1;
    @(negedge clk);
    walk_req = 1'b0;
    done = 1'b0;
    for (int c = 0; c < 60 && !done; c++) begin
      if (poke && c == 2) begin
        walk_lin = 32'h0080_1000; walk_wr = 1'b1; walk_user = 1'b1;
        walk_req = 1'b1;
      end else walk_req = 1'b0;
      if (fill_vld) begin got_fill = 1'b1; got_vpn = fill_vpn; got_frame = fill_frame; end
      if (flt_vld)  begin got_flt = 1'b1; got_code = flt_code; end
      if ((got_fill || got_flt) && !walk_busy) done = 1'b1;
      else @(negedge clk);
    end
    walk_req = 1'b0;
    if (!done) chk(1'b0, "R11", "walk did not finish (watchdog)", 0, 1);
  endtask

  task automatic t_reset;
    chk_eq("R1", "busy", {31'b0, walk_busy}, 0);
    chk_eq("R1", "mem_req", {31'b0, mem_req}, 0);
    chk_eq("R1", "strobes", {30'b0, fill_vld, flt_vld}, 0);
    chk_eq("R1", "flt_addr", flt_addr, 0);
    chk_eq("R1", "flt_code", {16'b0, flt_code}, 0);
  endtask

  task automatic t_full_miss;
    logic [31:0] lin = 32'h0040_3ABC;
    logic [31:0] da, ta;
    mem[dir_at(lin)] = 32'h0002_0007;
    da = dir_at(lin); ta = tbl_at(lin);
    mem[ta] = 32'h0055_5007;
    run_walk(lin, 1'b0, 1'b1, 1'b0);
    chk_eq("R4", "txn count", log_n, 4);
    chk_txn("R2", 0, da, 1'b0, 0);
    chk_txn("R4", 1, da, 1'b1, 32'h0002_0027);
    chk_txn("R5", 2, ta, 1'b0, 0);
    chk_txn("R7", 3, ta, 1'b1, 32'h0055_5027);
    chk_eq("R11", "fill seen", {30'b0, got_fill, got_flt}, 32'h2);
    chk_eq("R11", "fill vpn", {12'b0, got_vpn}, 32'h00403);
    chk_eq("R11", "fill frame", {12'b0, got_frame}, 32'h00555);
  endtask

  task automatic t_dirty_write;
    logic [31:0] lin = 32'h0040_3ABC;
    run_walk(lin, 1'b1, 1'b0, 1'b0);
    chk_eq("R7", "txn count", log_n, 3);
    chk_txn("R7", 2, tbl_at(lin), 1'b1, 32'h0055_5067);
    chk_eq("R11", "fill seen", {31'b0, got_fill}, 1);
  endtask

  task automatic t_no_writeback;
    logic [31:0] lin = 32'h0040_3ABC;
    run_walk(lin, 1'b1, 1'b1, 1'b0);
    chk_eq("R7", "no write-back count", log_n, 2);
    chk_eq("R4", "dir read only", {31'b0, log_we[0] | log_we[1]}, 0);
  endtask

  task automatic t_dir_absent;
    logic [31:0] lin = 32'h0080_1000;
    run_walk(lin, 1'b1, 1'b1, 1'b0);
    chk_eq("R3", "single txn", log_n, 1);
    chk_eq("R3", "fault seen", {30'b0, got_fill, got_flt}, 1);
    chk_eq("R9", "code user write not-present", {16'b0, got_code}, 32'h6);
    chk_eq("R10", "fault addr", flt_addr, lin);
  endtask

  task automatic t_tbl_absent;
    logic [31:0] lin = 32'h00C0_5000;
    mem[dir_at(lin)] = 32'h0003_0027;
    mem[tbl_at(lin)] = 32'h0006_6000;
    run_walk(lin, 1'b0, 1'b0, 1'b0);
    chk_eq("R6", "txn count", log_n, 2);
    chk_eq("R6", "code", {16'b0, got_code}, 0);
    chk_eq("R6", "fault seen", {31'b0, got_flt}, 1);
  endtask

  task automatic t_user_sup_page;
    logic [31:0] lin = 32'h0100_2000;
    mem[dir_at(lin)] = 32'h0004_0027;
    mem[tbl_at(lin)] = 32'h0007_7023;
    run_walk(lin, 1'b0, 1'b1, 1'b0);
    chk_eq("R8", "code user read prot", {16'b0, got_code}, 32'h5);
    chk_eq("R8", "no table write", rd_mem(tbl_at(lin)), 32'h0007_7023);
    chk_eq("R10", "fault addr", flt_addr, lin);
  endtask

  task automatic t_user_ro;
    logic [31:0] lin = 32'h0140_7000;
    mem[dir_at(lin)] = 32'h0005_0025;
    mem[tbl_at(lin)] = 32'h0008_8067;
    run_walk(lin, 1'b1, 1'b1, 1'b0);
    chk_eq("R8", "code user write prot", {16'b0, got_code}, 32'h7);
    chk_eq("R9", "upper code bits", {16'b0, got_code & 16'hFFF8}, 0);
  endtask

  task automatic t_sup_ro;
    logic [31:0] lin = 32'h0140_7000;
    run_walk(lin, 1'b1, 1'b0, 1'b0);
    chk_eq("R8", "supervisor write ok", {30'b0, got_fill, got_flt}, 32'h2);
    chk_eq("R8", "frame", {12'b0, got_frame}, 32'h00088);
    chk_eq("R10", "fault addr held", flt_addr, 32'h0140_7000);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] lin = 32'h0040_3ABC;
    run_walk(lin, 1'b0, 1'b1, 1'b1);
    chk_eq("R12", "vpn of first request", {12'b0, got_vpn}, 32'h00403);
    chk_eq("R12", "no fault from poke", {31'b0, got_flt}, 0);
    repeat (5) @(negedge clk);
    chk_eq("R12", "stays idle", {31'b0, walk_busy}, 0);
    chk_eq("R12", "no extra txn", log_n, 2);
    chk_eq("R10", "fault addr unchanged", flt_addr, 32'h0140_7000);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_miss();
    t_dirty_write();
    t_no_writeback();
    t_dir_absent();
    t_tbl_absent();
    t_user_sup_page();
    t_user_ro();
    t_sup_ro();
    t_busy_ignore();
    finish_run();
  end
endmodule